// File: doc/BRIEF.md
# 8:1 DDR output serializer

This block turns an 8-bit parallel word into a serial bit stream at double data rate. User logic presents a word once per cycle of a slow clock. The block shifts that word out on a fast clock that runs at exactly four times the slow rate and is phase-aligned to it, releasing two bits per fast cycle. The serial stream is modelled as two registered bits per fast cycle: a rise bit for the rising edge and a fall bit for the falling edge. A pad stage outside this block would merge the two into one line.

The word is split across two slices. A master slice holds the six earliest bits. A slave slice holds the two latest bits and passes them into the master's shift chain over a cascade path, so only the master drives the output. A control state machine runs in the fast domain. It sees each slow-clock capture through a toggle flag that crosses into the fast domain, and it walks through the states ST_EMPTY, ST_PAIR_AB, ST_PAIR_CD, ST_PAIR_EF and ST_PAIR_GH. Each ST_PAIR state names the bit pair that the output registers take on the next fast edge.

State transitions:
- reset goes to ST_EMPTY.
- A load goes to ST_PAIR_AB from any state.
- With no load, ST_PAIR_AB goes to ST_PAIR_CD, then ST_PAIR_EF, then ST_PAIR_GH.
- ST_PAIR_GH with no load goes to ST_EMPTY.
- ST_EMPTY with no load stays in ST_EMPTY.

In steady state a load arrives exactly as ST_PAIR_GH is active, so the words run back to back.

Top module: `ddr_serializer_8to1`

## Requirements
- R1: Bits leave in the order `word_in[0]` first through `word_in[7]` last. `word_in[0]` is bit A and `word_in[7]` is bit H.
- R2: In each fast cycle the earlier bit of a pair is on `ser_rise` and the later bit is on `ser_fall`. In pair k, `ser_rise` = `word_in[2k]` and `ser_fall` = `word_in[2k+1]`.
- R3: The word serialized is the value of `word_in` at a rising edge of `clk_slow`. Values that `word_in` holds only between slow edges have no effect on the output.
- R4: Bit A of a word captured at a slow edge appears on `ser_rise` after the fourth rising edge of `clk_fast` that follows that slow edge.
- R5: The first pair of the next word follows the last pair of the current word in the very next fast cycle, with no gap.
- R6: Bits G and H (`word_in[7:6]`) are captured by the slave slice and come out as the fourth pair of the word, through the master.
- R7: While `rst` is high the outputs are 0. After `rst` is released they stay 0 until the first word captured after release reaches the output.
- R8: The control state machine follows the transitions listed above. A load only ever arrives in ST_EMPTY or ST_PAIR_GH.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_fast | input | 1 | Bit clock, four times the slow clock rate and phase-aligned to it |
| clk_slow | input | 1 | Word clock; `word_in` is captured on its rising edge |
| rst | input | 1 | Synchronous active-high reset, seen by both clock domains |
| word_in | input | 8 | Parallel word; bit 0 leaves first |
| ser_rise | output | 1 | Serial bit for the rising half of the current fast cycle |
| ser_fall | output | 1 | Serial bit for the falling half of the current fast cycle |

## Verification
Single-hot words, walked across all eight positions, separate a wrong bit order from a swap of rise and fall slots, and also expose an off-by-one latency. Patterns that load only the top two bits isolate the slave cascade path. Back-to-back complementary words show any gap or overlap at word boundaries. A word preceded by a different value that is withdrawn before the slow edge confirms that only the edge value counts. A reset in the middle of the stream, followed by a run of pseudo-random words, checks both the quiet window after reset and general data handling.

// File: rtl/ser_pkg.sv
package ser_pkg;
    localparam int SER_WORD_W   = 8;
    localparam int SER_STEP     = 2;   // bits per fast cycle (DDR)
    localparam int SER_MASTER_W = 6;
    localparam int SER_SLAVE_W  = SER_WORD_W - SER_MASTER_W;
    localparam int SER_SYNC_N   = 3;   // toggle synchronizer depth, sets load latency

    typedef enum logic [2:0] {
        ST_EMPTY,
        ST_PAIR_AB,
        ST_PAIR_CD,
        ST_PAIR_EF,
        ST_PAIR_GH
    } ser_state_e;
endpackage

// File: rtl/ser_slice.sv
module ser_slice #(
    parameter int NIN  = 6,
    parameter int STEP = 2
) (
    input  logic            clk_slow,
    input  logic            clk_fast,
    input  logic            rst,
    input  logic [NIN-1:0]  d_in,
    input  logic            load,
    input  logic            shift,
    input  logic [STEP-1:0] casc_in,
    output logic [STEP-1:0] front
);
    logic [NIN-1:0] hold_q;
    logic [NIN-1:0] chain_q;

    // parallel capture in the word domain
    always_ff @(posedge clk_slow) begin
        if (rst) hold_q <= '0;
        else     hold_q <= d_in;
    end

    // shift chain in the bit domain; index 0 leaves first
    generate
        if (NIN > STEP) begin : g_deep
            always_ff @(posedge clk_fast) begin
                if (rst)        chain_q <= '0;
                else if (load)  chain_q <= hold_q;
                else if (shift) chain_q <= {casc_in, chain_q[NIN-1:STEP]};
            end
        end else begin : g_short
            always_ff @(posedge clk_fast) begin
                if (rst)        chain_q <= '0;
                else if (load)  chain_q <= hold_q;
                else if (shift) chain_q <= casc_in;
            end
        end
    endgenerate

    assign front = chain_q[STEP-1:0];
endmodule

// File: rtl/ser_ctrl.sv
module ser_ctrl
    import ser_pkg::*;
(
    input  logic       clk_slow,
    input  logic       clk_fast,
    input  logic       rst,
    output logic       load,
    output logic       shift,
    output ser_state_e state
);
    logic                  tog_q;
    logic [SER_SYNC_N-1:0] sync_q;
    ser_state_e            state_nx;

    // one flip per captured word
    always_ff @(posedge clk_slow) begin
        if (rst) tog_q <= 1'b0;
        else     tog_q <= ~tog_q;
    end

    always_ff @(posedge clk_fast) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[SER_SYNC_N-2:0], tog_q};
    end

    assign load = sync_q[SER_SYNC_N-2] ^ sync_q[SER_SYNC_N-1];

    // state register
    always_ff @(posedge clk_fast) begin
        if (rst) state <= ST_EMPTY;
        else     state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        if (load) begin
            state_nx = ST_PAIR_AB;
        end else begin
            unique case (state)
                ST_EMPTY:   state_nx = ST_EMPTY;
                ST_PAIR_AB: state_nx = ST_PAIR_CD;
                ST_PAIR_CD: state_nx = ST_PAIR_EF;
                ST_PAIR_EF: state_nx = ST_PAIR_GH;
                ST_PAIR_GH: state_nx = ST_EMPTY;
                default:    state_nx = ST_EMPTY;
            endcase
        end
    end

    // outputs
    always_comb begin
        unique case (state)
            ST_EMPTY: shift = 1'b0;
            default:  shift = ~load;
        endcase
    end
endmodule

// File: rtl/ddr_serializer_8to1.sv
module ddr_serializer_8to1
    import ser_pkg::*;
(
    input  logic                  clk_fast,
    input  logic                  clk_slow,
    input  logic                  rst,
    input  logic [SER_WORD_W-1:0] word_in,
    output logic                  ser_rise,
    output logic                  ser_fall
);
    logic                ctl_load;
    logic                ctl_shift;
    ser_state_e          ctl_state;
    logic [SER_STEP-1:0] casc;
    logic [SER_STEP-1:0] m_front;
    logic                emit;

    ser_ctrl u_ctrl (
        .clk_slow (clk_slow),
        .clk_fast (clk_fast),
        .rst      (rst),
        .load     (ctl_load),
        .shift    (ctl_shift),
        .state    (ctl_state)
    );

    ser_slice #(.NIN(SER_SLAVE_W), .STEP(SER_STEP)) u_slave (
        .clk_slow (clk_slow),
        .clk_fast (clk_fast),
        .rst      (rst),
        .d_in     (word_in[SER_WORD_W-1:SER_MASTER_W]),
        .load     (ctl_load),
        .shift    (ctl_shift),
        .casc_in  ({SER_STEP{1'b0}}),
        .front    (casc)
    );

    ser_slice #(.NIN(SER_MASTER_W), .STEP(SER_STEP)) u_master (
        .clk_slow (clk_slow),
        .clk_fast (clk_fast),
        .rst      (rst),
        .d_in     (word_in[SER_MASTER_W-1:0]),
        .load     (ctl_load),
        .shift    (ctl_shift),
        .casc_in  (casc),
        .front    (m_front)
    );

    assign emit = (ctl_state != ST_EMPTY);

    always_ff @(posedge clk_fast) begin
        if (rst || !emit) begin
            ser_rise <= 1'b0;
            ser_fall <= 1'b0;
        end else begin
            ser_rise <= m_front[0];
            ser_fall <= m_front[1];
        end
    end
endmodule

// File: rtl/ddr_ser_checks.sv
module ddr_ser_checks
    import ser_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       load,
    input ser_state_e st,
    input logic       rise,
    input logic       fall
);
    // R8: loads land only at a word boundary
    a_r8_load_aligned: assert property (@(posedge clk) disable iff (rst)
        load |-> (st == ST_EMPTY || st == ST_PAIR_GH));

    a_r8_load_starts: assert property (@(posedge clk) disable iff (rst)
        load |=> (st == ST_PAIR_AB));

    a_r8_ab_to_cd: assert property (@(posedge clk) disable iff (rst)
        (!load && st == ST_PAIR_AB) |=> (st == ST_PAIR_CD));

    a_r8_cd_to_ef: assert property (@(posedge clk) disable iff (rst)
        (!load && st == ST_PAIR_CD) |=> (st == ST_PAIR_EF));

    a_r8_ef_to_gh: assert property (@(posedge clk) disable iff (rst)
        (!load && st == ST_PAIR_EF) |=> (st == ST_PAIR_GH));

    a_r8_gh_drains: assert property (@(posedge clk) disable iff (rst)
        (!load && st == ST_PAIR_GH) |=> (st == ST_EMPTY));

    // R7: no data leaves while nothing is queued
    a_r7_quiet_when_empty: assert property (@(posedge clk) disable iff (rst)
        (st == ST_EMPTY) |=> (!rise && !fall));

    // R5: a word boundary never inserts an idle cycle
    a_r5_no_gap: assert property (@(posedge clk) disable iff (rst)
        (st == ST_PAIR_GH && load) |=> (st != ST_EMPTY));
endmodule

bind ddr_serializer_8to1 ddr_ser_checks u_chk (
    .clk  (clk_fast),
    .rst  (rst),
    .load (ctl_load),
    .st   (ctl_state),
    .rise (ser_rise),
    .fall (ser_fall)
);

// File: tb/sim_ddr_serializer_8to1.sv
`timescale 1ns/1ps
module sim_ddr_serializer_8to1;
    logic       clk_fast = 1'b0;
    logic       clk_slow = 1'b0;
    logic       rst      = 1'b1;
    logic [7:0] word_in  = 8'h00;
    logic       ser_rise;
    logic       ser_fall;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    bit done  = 1'b0;

    typedef struct {
        int    due;
        logic  r;
        logic  f;
        string tag;
    } exp_t;
    exp_t exp_q[$];

    ddr_serializer_8to1 u0 (
        .clk_fast (clk_fast),
        .clk_slow (clk_slow),
        .rst      (rst),
        .word_in  (word_in),
        .ser_rise (ser_rise),
        .ser_fall (ser_fall)
    );

    // 250 MHz fast clock, slow clock at one quarter, rising edges aligned
    initial begin
        #2;
        for (int ph = 0; ; ph++) begin
            clk_fast = 1'b1;
            if (ph % 4 == 0) clk_slow = 1'b1;
            if (ph % 4 == 2) clk_slow = 1'b0;
            #2;
            clk_fast = 1'b0;
            #2;
        end
    end

    always @(posedge clk_fast) cyc <= cyc + 1;

    task automatic push_item(int due, logic r, logic f, string tag);
        exp_t e;
        e.due = due; e.r = r; e.f = f; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // driver: word visible after slow edge n is captured at n+4, emitted at n+8..n+11
    task automatic send(logic [7:0] w, string extra, bit use_junk, logic [7:0] junk);
        int n;
        @(posedge clk_slow);
        #1;
        n = cyc;
        if (use_junk) begin
            word_in = junk;
            #8;
        end
        word_in = w;
        for (int j = 0; j < 4; j++) begin
            string t;
            t = (j == 0) ? "R1 R2 R4" : (j == 3) ? "R1 R2 R6" : "R1 R2";
            push_item(n + 8 + j, w[2*j], w[2*j+1], {t, extra});
        end
    endtask

    // release reset right after a slow edge; zero word is captured 4 edges later
    task automatic release_now();
        int n;
        n = cyc;
        rst = 1'b0;
        word_in = 8'h00;
        for (int k = 1; k <= 11; k++) push_item(n + k, 1'b0, 1'b0, "R7");
    endtask

    task automatic mid_reset(int slow_cycles);
        int m;
        @(posedge clk_slow);
        #1;
        m = cyc;
        rst = 1'b1;
        for (int i = exp_q.size() - 1; i >= 0; i--)
            if (exp_q[i].due > m) exp_q.delete(i);
        for (int k = 1; k <= 4 * slow_cycles; k++) push_item(m + k, 1'b0, 1'b0, "R7");
        repeat (slow_cycles) @(posedge clk_slow);
        #1;
        release_now();
    endtask

    // monitor: compare at falling edge of the fast clock
    initial begin
        forever begin
            @(negedge clk_fast);
            while (exp_q.size() > 0 && exp_q[0].due < cyc) begin
                total++; bad++;
                $display("FAIL %s missed at cycle %0d actual=none expected=%b%b",
                         exp_q[0].tag, exp_q[0].due, exp_q[0].r, exp_q[0].f);
                void'(exp_q.pop_front());
            end
            if (exp_q.size() > 0 && exp_q[0].due == cyc) begin
                total++;
                if (ser_rise !== exp_q[0].r || ser_fall !== exp_q[0].f) begin
                    bad++;
                    $display("FAIL %s cycle %0d actual=%b%b expected=%b%b",
                             exp_q[0].tag, cyc, ser_rise, ser_fall, exp_q[0].r, exp_q[0].f);
                end
                void'(exp_q.pop_front());
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk_fast);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
            summary();
        end
    end

    initial begin
        logic [7:0] lfsr;
        repeat (3) @(posedge clk_slow);
        #1;
        // R7: reset state at the ports
        total++;
        if (ser_rise !== 1'b0 || ser_fall !== 1'b0) begin
            bad++;
            $display("FAIL R7 reset state actual=%b%b expected=00", ser_rise, ser_fall);
        end
        release_now();

        // R1 R2 R4: single-hot walk
        for (int b = 0; b < 8; b++) send(8'h01 << b, "", 1'b0, 8'h00);
        // R2: rise/fall slot patterns
        send(8'h55, "", 1'b0, 8'h00);
        send(8'hAA, "", 1'b0, 8'h00);
        send(8'h33, "", 1'b0, 8'h00);
        send(8'hCC, "", 1'b0, 8'h00);
        // R6: slave-only bits
        send(8'hC0, " R6", 1'b0, 8'h00);
        send(8'h40, " R6", 1'b0, 8'h00);
        send(8'h80, " R6", 1'b0, 8'h00);
        send(8'h3F, " R6", 1'b0, 8'h00);
        // R5: back-to-back complements
        for (int i = 0; i < 4; i++) send((i % 2) ? 8'hFF : 8'h00, " R5", 1'b0, 8'h00);
        send(8'h81, " R5", 1'b0, 8'h00);
        send(8'h7E, " R5", 1'b0, 8'h00);
        // R3: value withdrawn before the slow edge is ignored
        send(8'h96, " R3", 1'b1, 8'h69);
        send(8'h0F, " R3", 1'b1, 8'hF0);
        send(8'hE4, " R3", 1'b1, 8'h1B);
        // R7: reset mid-stream, then quiet window
        mid_reset(2);
        lfsr = 8'hB5;
        for (int i = 0; i < 16; i++) begin
            send(lfsr, "", 1'b0, 8'h00);
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        end
        while (exp_q.size() > 0) @(negedge clk_fast);
        done = 1'b1;
        summary();
    end
endmodule